// File: doc/BRIEF.md
# CPU Clock Stop and Power-Down Controller

This block turns one master clock into a set of gated CPU clocks and memory (SDRAM) clocks. Every output is a registered level, and each output clock runs at half the master rate. It has two active-low requests. The first stops the CPU clocks. The second puts the whole clock tree into a power-down state. Each request is synchronised into the master clock domain before it is used. Enable changes are made only while the generated clock is low. As a result, an output either completes a whole high phase or does not start one, and no runt pulse can appear.

Two shared pins change role according to a strap input. When the strap is 0, the two pins are inputs: a CPU stop request and a PCI stop request. The PCI request is synchronised and sent out as a run level for a downstream PCI gate. When the strap is 1, the two pins become two extra memory clock outputs with their drivers enabled, and both stop requests count as deasserted.

Power-down overrides the CPU stop request. When power-down is released, a wake counter of programmable length runs before any output clock restarts. The same wake path is used when reset is released.

Top module: `clkstop_ctrl`

## Requirements
- R1: Each output clock is high for exactly one master cycle at a time. While an output runs, it produces one high cycle in every two master cycles.
- R2: All CPU outputs are identical. Whenever a CPU output is high, every memory output is high as well, so the two groups are in phase.
- R3: With strap 0, driving shared_in_i[0] low stops the CPU outputs. From the 4th master cycle after the request, the CPU outputs stay low for as long as the request is held. The memory outputs keep running.
- R4: When the CPU stop request is removed, the first CPU high cycle appears in master cycle 4 or 5 after the change, and it is a full high cycle.
- R5: Driving pd_n_i low brings every clock output low, including the shared outputs, and pci_run_o low as well. From the 5th master cycle after the request, all of these stay low.
- R6: When pd_n_i returns high, all outputs stay low through master cycle WAKE_CYCLES+4. The first memory high cycle appears in cycle WAKE_CYCLES+5 or WAKE_CYCLES+6.
- R7: Power-down has priority. A high CPU stop request does not start the CPU outputs during power-down. A CPU stop request that is low when power-down is released keeps the CPU outputs parked, while the memory outputs restart.
- R8: With strap 1, shared_oe_o becomes 2'b11 within 4 master cycles. Both bits of shared_out_o then equal sdram_clk_o[0]. Low levels on shared_in_i are ignored: the CPU outputs keep running and pci_run_o stays 1.
- R9: With strap 0, shared_oe_o is 2'b00 and shared_out_o is 2'b00.
- R10: With strap 0 and the block running, pci_run_o follows shared_in_i[1] (1 means run). The new value appears in the 2nd master cycle after the change, and the 1st cycle still shows the old value.
- R11: While rst_n is low, all outputs are 0. After reset is released, the block goes through the wake sequence of R6 before any clock runs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock, twice the output clock rate |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| mode_i | input | 1 | Strap: 0 means the shared pins are stop inputs, 1 means they are memory clock outputs |
| pd_n_i | input | 1 | Active-low power-down request |
| shared_in_i | input | 2 | Shared pins as inputs: bit 0 is the CPU stop request and bit 1 is the PCI stop request, both active low |
| cpu_clk_o | output | N_CPU | Gated CPU clocks |
| sdram_clk_o | output | N_SD | Memory clocks, stopped only by power-down |
| shared_out_o | output | 2 | Extra memory clocks driven on the shared pins |
| shared_oe_o | output | 2 | Output enables for the shared pins |
| pci_run_o | output | 1 | Synchronised PCI run level, 0 during power-down |

## Verification
Each result has a fixed due cycle, counted in master cycles from the negative edge at which the stimulus is driven. A PCI run change is due in cycle 2. A CPU park is due from cycle 4, and a CPU restart in cycle 4 or 5. Power-down entry is due from cycle 5. A wake is due in cycle WAKE_CYCLES+5 or WAKE_CYCLES+6, and a strap change by cycle 4. The bench samples every output on the negative edge of each counted cycle. It checks quiet windows only after the latest due cycle, and it checks restarts only inside their two-cycle window. Request arrival is swept over both output phases. A monitor checks pulse width and group alignment on every cycle in between.

// File: rtl/ckctl_pkg.sv
package ckctl_pkg;

  typedef enum logic [1:0] {
    PW_DOWN = 2'd0,
    PW_WAKE = 2'd1,
    PW_RUN  = 2'd2
  } pw_state_e;

  localparam int unsigned SYNC_STAGES = 2;

endpackage

// File: rtl/ckctl_sync.sv
module ckctl_sync #(
  parameter int unsigned W = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  import ckctl_pkg::*;

  genvar gi;
  generate
    for (gi = 0; gi < W; gi++) begin : g_bit
      logic [SYNC_STAGES-1:0] stg_q;
      logic [SYNC_STAGES-1:0] stg_d;

      always_comb begin
        stg_d = {stg_q[SYNC_STAGES-2:0], d_i[gi]};
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stg_q <= '0;
        else        stg_q <= stg_d;
      end

      assign q_o[gi] = stg_q[SYNC_STAGES-1];
    end
  endgenerate

endmodule

// File: rtl/ckctl_wake.sv
module ckctl_wake #(
  parameter int unsigned WAKE_CYCLES = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pd_run_i,
  output logic pwr_ok_o
);
  import ckctl_pkg::*;

  localparam int unsigned CNT_W = (WAKE_CYCLES < 2) ? 1 : $clog2(WAKE_CYCLES);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(WAKE_CYCLES - 1);

  pw_state_e        st_q, st_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             cnt_en;

  always_comb begin
    st_d   = st_q;
    cnt_d  = cnt_q;
    cnt_en = 1'b0;
    unique case (st_q)
      PW_DOWN: begin
        if (pd_run_i) begin
          st_d   = PW_WAKE;
          cnt_d  = '0;
          cnt_en = 1'b1;
        end
      end
      PW_WAKE: begin
        if (!pd_run_i) begin
          st_d = PW_DOWN;
        end else if (cnt_q == CNT_LAST) begin
          st_d = PW_RUN;
        end else begin
          cnt_d  = cnt_q + 1'b1;
          cnt_en = 1'b1;
        end
      end
      PW_RUN: begin
        if (!pd_run_i) st_d = PW_DOWN;
      end
      default: st_d = PW_DOWN;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= PW_DOWN;
    else        st_q <= st_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign pwr_ok_o = (st_q == PW_RUN);

endmodule

// File: rtl/ckctl_gate.sv
module ckctl_gate #(
  parameter int unsigned N = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         ph_i,
  input  logic         en_req_i,
  output logic [N-1:0] clk_o
);

  logic en_q;
  logic en_d;
  logic en_upd;

  // The enable may change only at the edge that ends a high phase.
  always_comb begin
    en_upd = ph_i;
    en_d   = en_req_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      en_q <= 1'b0;
    else if (en_upd) en_q <= en_d;
  end

  genvar gi;
  generate
    for (gi = 0; gi < N; gi++) begin : g_out
      logic out_q;
      logic out_d;

      always_comb begin
        out_d = ~ph_i & en_q;
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) out_q <= 1'b0;
        else        out_q <= out_d;
      end

      assign clk_o[gi] = out_q;
    end
  endgenerate

endmodule

// File: rtl/clkstop_ctrl.sv
module clkstop_ctrl #(
  parameter int unsigned N_CPU       = 4,
  parameter int unsigned N_SD        = 6,
  parameter int unsigned WAKE_CYCLES = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             mode_i,
  input  logic             pd_n_i,
  input  logic [1:0]       shared_in_i,
  output logic [N_CPU-1:0] cpu_clk_o,
  output logic [N_SD-1:0]  sdram_clk_o,
  output logic [1:0]       shared_out_o,
  output logic [1:0]       shared_oe_o,
  output logic             pci_run_o
);

  localparam int unsigned N_SHARED = 2;
  localparam int unsigned N_REQ    = 4;
  localparam int unsigned IDX_CPU  = 0;
  localparam int unsigned IDX_PCI  = 1;
  localparam int unsigned IDX_PD   = 2;
  localparam int unsigned IDX_MODE = 3;

  // Reset: asserted asynchronously, released on a clock edge.
  logic [1:0] rst_sh_q;
  logic       rst_i_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sh_q <= 2'b00;
    else        rst_sh_q <= {rst_sh_q[0], 1'b1};
  end

  assign rst_i_n = rst_sh_q[1];

  // Request synchronisers.
  logic [N_REQ-1:0] req_raw;
  logic [N_REQ-1:0] req_s;

  always_comb begin
    req_raw           = '0;
    req_raw[IDX_CPU]  = shared_in_i[0];
    req_raw[IDX_PCI]  = shared_in_i[1];
    req_raw[IDX_PD]   = pd_n_i;
    req_raw[IDX_MODE] = mode_i;
  end

  ckctl_sync #(.W(N_REQ)) u_sync (
    .clk   (clk),
    .rst_n (rst_i_n),
    .d_i   (req_raw),
    .q_o   (req_s)
  );

  logic mode_s;
  logic cpu_run_s;
  logic pci_run_s;

  always_comb begin
    mode_s    = req_s[IDX_MODE];
    cpu_run_s = req_s[IDX_CPU] | mode_s;
    pci_run_s = req_s[IDX_PCI] | mode_s;
  end

  // Power sequencing.
  logic pwr_ok;

  ckctl_wake #(.WAKE_CYCLES(WAKE_CYCLES)) u_wake (
    .clk      (clk),
    .rst_n    (rst_i_n),
    .pd_run_i (req_s[IDX_PD]),
    .pwr_ok_o (pwr_ok)
  );

  // Free-running phase: a value of 1 ends the high half of an output cycle.
  logic ph_q;
  logic ph_d;

  always_comb ph_d = ~ph_q;

  always_ff @(posedge clk or negedge rst_i_n) begin
    if (!rst_i_n) ph_q <= 1'b0;
    else          ph_q <= ph_d;
  end

  // Gate requests for each output group.
  logic cpu_req;
  logic sd_req;
  logic sh_req;

  always_comb begin
    sd_req  = pwr_ok;
    cpu_req = pwr_ok & cpu_run_s;
    sh_req  = pwr_ok & mode_s;
  end

  ckctl_gate #(.N(N_CPU)) u_gate_cpu (
    .clk      (clk),
    .rst_n    (rst_i_n),
    .ph_i     (ph_q),
    .en_req_i (cpu_req),
    .clk_o    (cpu_clk_o)
  );

  ckctl_gate #(.N(N_SD)) u_gate_sd (
    .clk      (clk),
    .rst_n    (rst_i_n),
    .ph_i     (ph_q),
    .en_req_i (sd_req),
    .clk_o    (sdram_clk_o)
  );

  ckctl_gate #(.N(N_SHARED)) u_gate_sh (
    .clk      (clk),
    .rst_n    (rst_i_n),
    .ph_i     (ph_q),
    .en_req_i (sh_req),
    .clk_o    (shared_out_o)
  );

  // Pin direction follows the strap and changes only while the pins are low.
  logic oe_q;
  logic oe_d;
  logic oe_upd;

  always_comb begin
    oe_upd = ph_q;
    oe_d   = mode_s;
  end

  always_ff @(posedge clk or negedge rst_i_n) begin
    if (!rst_i_n)    oe_q <= 1'b0;
    else if (oe_upd) oe_q <= oe_d;
  end

  assign shared_oe_o = {N_SHARED{oe_q}};
  assign pci_run_o   = pci_run_s & pwr_ok;

endmodule

// File: rtl/clkstop_ctrl_chk.sv
module clkstop_ctrl_chk #(
  parameter int unsigned N_CPU = 4,
  parameter int unsigned N_SD  = 6
) (
  input logic             clk,
  input logic             rst_n,
  input logic             pd_n_i,
  input logic [N_CPU-1:0] cpu_clk_o,
  input logic [N_SD-1:0]  sdram_clk_o,
  input logic [1:0]       shared_out_o,
  input logic [1:0]       shared_oe_o,
  input logic             pci_run_o
);

  a_r1_cpu_single_high: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_clk_o[0] |=> !cpu_clk_o[0]);

  a_r1_sd_single_high: assert property (@(posedge clk) disable iff (!rst_n)
    sdram_clk_o[0] |=> !sdram_clk_o[0]);

  a_r2_cpu_inside_sd: assert property (@(posedge clk) disable iff (!rst_n)
    (|cpu_clk_o) |-> (&sdram_clk_o));

  a_r2_cpu_group_equal: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_clk_o == '0) || (&cpu_clk_o));

  a_r9_shared_quiet_when_input: assert property (@(posedge clk) disable iff (!rst_n)
    (shared_oe_o == 2'b00) |-> (shared_out_o == 2'b00));

  a_r5_pd_all_low: assert property (@(posedge clk) disable iff (!rst_n)
    (!pd_n_i && $past(!pd_n_i, 1) && $past(!pd_n_i, 2) && $past(!pd_n_i, 3)
     && $past(!pd_n_i, 4) && $past(!pd_n_i, 5))
    |-> (cpu_clk_o == '0 && sdram_clk_o == '0 && shared_out_o == 2'b00 && !pci_run_o));

endmodule

bind clkstop_ctrl clkstop_ctrl_chk #(.N_CPU(N_CPU), .N_SD(N_SD)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .pd_n_i       (pd_n_i),
  .cpu_clk_o    (cpu_clk_o),
  .sdram_clk_o  (sdram_clk_o),
  .shared_out_o (shared_out_o),
  .shared_oe_o  (shared_oe_o),
  .pci_run_o    (pci_run_o)
);

// File: tb/clkstop_ctrl_tb_top.sv
module clkstop_ctrl_tb_top;

  localparam int NC = 4;
  localparam int NS = 6;
  localparam int W  = 16;

  logic          clk;
  logic          rst_n;
  logic          mode;
  logic          pd_n;
  logic [1:0]    sh_in;
  logic [NC-1:0] cpu;
  logic [NS-1:0] sd;
  logic [1:0]    sh_out;
  logic [1:0]    sh_oe;
  logic          pci_run;

  int checks = 0;
  int errors = 0;
  bit mon_en = 0;
  bit prev_cpu = 0, prev_sd = 0, prev_sh = 0;

  initial clk = 1'b0;
  always #10 clk = ~clk;

  clkstop_ctrl #(.N_CPU(NC), .N_SD(NS), .WAKE_CYCLES(W)) dut_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .mode_i       (mode),
    .pd_n_i       (pd_n),
    .shared_in_i  (sh_in),
    .cpu_clk_o    (cpu),
    .sdram_clk_o  (sd),
    .shared_out_o (sh_out),
    .shared_oe_o  (sh_oe),
    .pci_run_o    (pci_run)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  function automatic bit all_low();
    return (cpu == '0) && (sd == '0) && (sh_out == 2'b00);
  endfunction

  // Every-cycle monitor for pulse width and group alignment.
  always @(negedge clk) begin
    if (mon_en) begin
      chk(!(prev_cpu && cpu[0]), "R1 cpu high width", 2, 1);
      chk(!(prev_sd && sd[0]), "R1 sdram high width", 2, 1);
      chk(!(prev_sh && sh_out[0]), "R1 shared high width", 2, 1);
      chk((cpu == '0) || (&cpu), "R2 cpu group equal", int'(cpu), 0);
      chk(!cpu[0] || (&sd), "R2 cpu high inside sdram high", int'(sd), (1 << NS) - 1);
    end
    prev_cpu = cpu[0];
    prev_sd  = sd[0];
    prev_sh  = sh_out[0];
  end

  // Wake after a release: quiet through cycle W+4, first high in cycle W+5 or W+6.
  task automatic check_wake(input string req);
    int first;
    bit quiet;
    quiet = 1;
    first = 0;
    for (int k = 1; k <= W + 8; k++) begin
      step(1);
      if (k <= W + 4 && !all_low()) quiet = 0;
      if (first == 0 && sd[0]) first = k;
    end
    chk(quiet, {req, " quiet before wake"}, 0, 1);
    chk(first == W + 5 || first == W + 6, {req, " first sdram high"}, first, W + 5);
  endtask

  initial begin
    rst_n = 0; mode = 0; pd_n = 1; sh_in = 2'b11;
    step(3);
    // R11: reset state
    chk(all_low() && sh_oe == 2'b00 && !pci_run, "R11 reset outputs",
        int'({cpu, sd, sh_out, sh_oe, pci_run}), 0);

    // R11 / R6: wake after reset release (two extra cycles of reset release)
    rst_n = 1;
    begin
      int first;
      bit quiet;
      quiet = 1;
      first = 0;
      for (int k = 1; k <= W + 12; k++) begin
        step(1);
        if (k <= W + 4 && !all_low()) quiet = 0;
        if (first == 0 && sd[0]) first = k;
      end
      chk(quiet, "R11 quiet after reset", 0, 1);
      chk(first == W + 7 || first == W + 8, "R11 first sdram high", first, W + 7);
    end
    mon_en = 1;

    // R1: period of two master cycles
    begin
      int nc, ns;
      nc = 0; ns = 0;
      for (int k = 0; k < 20; k++) begin
        step(1);
        nc += cpu[0];
        ns += sd[0];
      end
      chk(nc == 10, "R1 cpu highs in 20 cycles", nc, 10);
      chk(ns == 10, "R1 sdram highs in 20 cycles", ns, 10);
    end

    // R9: strap 0 keeps the shared pins undriven
    chk(sh_oe == 2'b00 && sh_out == 2'b00, "R9 shared idle", int'({sh_oe, sh_out}), 0);

    // R10: PCI run follows with a delay of two cycles
    chk(pci_run == 1'b1, "R10 pci run initial", pci_run, 1);
    sh_in[1] = 1'b0;
    step(1); chk(pci_run == 1'b1, "R10 pci old value cycle 1", pci_run, 1);
    step(1); chk(pci_run == 1'b0, "R10 pci new value cycle 2", pci_run, 0);
    sh_in[1] = 1'b1;
    step(1); chk(pci_run == 1'b0, "R10 pci old value cycle 1", pci_run, 0);
    step(1); chk(pci_run == 1'b1, "R10 pci new value cycle 2", pci_run, 1);

    // R3 / R4: CPU stop and restart, request arriving in both phases
    for (int off = 0; off < 2; off++) begin
      int ns, first;
      bit parked;
      step(off);
      sh_in[0] = 1'b0;
      parked = 1; ns = 0;
      for (int k = 1; k <= 13; k++) begin
        step(1);
        if (k >= 4) begin
          if (cpu != '0) parked = 0;
          ns += sd[0];
        end
      end
      chk(parked, "R3 cpu parked low", 0, 1);
      chk(ns == 5, "R3 sdram keeps running", ns, 5);
      sh_in[0] = 1'b1;
      first = 0;
      for (int k = 1; k <= 6; k++) begin
        step(1);
        if (first == 0 && cpu[0]) first = k;
      end
      chk(first == 4 || first == 5, "R4 cpu restart cycle", first, 4);
      step(6);
    end

    // R5: power-down entry, sweeping both phases; R7: stop high does not wake cpu
    for (int off = 0; off < 2; off++) begin
      bit low;
      step(off);
      pd_n = 1'b0;
      low = 1;
      for (int k = 1; k <= 14; k++) begin
        step(1);
        if (k >= 5 && (!all_low() || pci_run)) low = 0;
      end
      chk(low, "R5 all outputs low in power-down", 0, 1);
      chk(sh_in[0] == 1'b1 && cpu == '0, "R7 stop high ignored in power-down", int'(cpu), 0);
      if (off == 1) sh_in[0] = 1'b0;
      step(1);
      pd_n = 1'b1;
      check_wake("R6");
      if (off == 1) begin
        // R7: the stop request held through the wake keeps the cpu parked
        bit parked;
        int ns, first;
        parked = 1; ns = 0;
        for (int k = 0; k < 10; k++) begin
          step(1);
          if (cpu != '0) parked = 0;
          ns += sd[0];
        end
        chk(parked, "R7 cpu parked after wake", 0, 1);
        chk(ns == 5, "R7 sdram running after wake", ns, 5);
        sh_in[0] = 1'b1;
        first = 0;
        for (int k = 1; k <= 6; k++) begin
          step(1);
          if (first == 0 && cpu[0]) first = k;
        end
        chk(first == 4 || first == 5, "R4 cpu restart after wake", first, 4);
      end
      step(4);
    end

    // R8: strap 1 drives the shared pins and ignores the stop inputs
    mode = 1'b1;
    sh_in = 2'b00;
    step(4);
    chk(sh_oe == 2'b11, "R8 shared enables on", int'(sh_oe), 3);
    begin
      bit same;
      int nc;
      same = 1; nc = 0;
      for (int k = 0; k < 10; k++) begin
        step(1);
        if (sh_out != {2{sd[0]}}) same = 0;
        nc += cpu[0];
      end
      chk(same, "R8 shared follows sdram", int'(sh_out), int'({2{sd[0]}}));
      chk(nc == 5, "R8 cpu runs with stop pin low", nc, 5);
      chk(pci_run == 1'b1, "R8 pci run forced", pci_run, 1);
    end

    // R5 in strap 1: shared outputs also stop
    pd_n = 1'b0;
    begin
      bit low;
      low = 1;
      for (int k = 1; k <= 12; k++) begin
        step(1);
        if (k >= 5 && !all_low()) low = 0;
      end
      chk(low, "R5 shared low in power-down", int'(sh_out), 0);
    end
    pd_n = 1'b1;
    check_wake("R6 strap 1");

    // R9: back to strap 0
    mode = 1'b0;
    sh_in = 2'b11;
    step(4);
    chk(sh_oe == 2'b00, "R9 shared enables off", int'(sh_oe), 0);
    begin
      bit quiet;
      quiet = 1;
      for (int k = 0; k < 10; k++) begin
        step(1);
        if (sh_out != 2'b00) quiet = 0;
      end
      chk(quiet, "R9 shared outputs quiet", int'(sh_out), 0);
    end

    mon_en = 0;
    step(2);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(200000 * 20);
    checks++;
    errors++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule